// File: doc/BRIEF.md
# Discrete-Time Diffusion Network Array

This block models the transient response of a one-dimensional resistive network in discrete time. A row of node cells, sixteen by default, each holds a signed fixed-point value. A start pulse loads every node from its pixel intensity. The intensity is the node's starting charge and is not applied again afterwards. The sequencer then runs a programmed number of update steps. In each step every node moves toward the mean of its two neighbours, which spreads an impulse into a bell-shaped profile. A shared leak term also scales each node up or down, and its direction is chosen per step from a sign pattern.

When the last step completes, the block pulses done and shifts the node values out on a serial port, one word per cycle. By alternating the leak direction between steps, a host keeps the spreading profile close to a useful amplitude. Under fixed-point arithmetic a pure leak would let the profile decay toward zero.

Top module: `diffnet_array`

## Requirements
- R1: After reset, busy_o, done_o and dout_valid_o are all 0.
- R2: A start_i pulse while idle loads node i from pix_i[i*8 +: 8] as pixel·256, meaning the pixel sits in the integer part of a Q8.8 word. A value above 32767 loads as 32767. With steps_i = 0 the loaded values are read out unchanged.
- R3: done_o rises in the cycle after the N-th rising clock edge that follows the edge sampling start_i. N is steps_i, in the range 0 to 31. When N is 0, done_o rises in the cycle after the start edge itself.
- R4: Each step computes v' = v + ((l + r − 2v) >>> kc_i) + g. Here g is −(v >>> kg_i) for a decay step and +(v >>> kg_i) for an amplify step. The result saturates to the range −32768 to 32767.
- R5: Node 0 uses its own value as its missing left neighbour, and node NODES−1 uses its own value as its missing right neighbour. No charge flows across either end.
- R6: All nodes update from the values of the previous step, so an impulse at node 7 stays mirror-symmetric about node 7 for as long as neither edge has been reached.
- R7: Step k, counted from 0, uses bit k of sign_pat_i. Bit value 0 means decay and bit value 1 means amplify. With decay alone the peak of an impulse falls strictly from one step count to the next.
- R8: After the last step, dout_valid_o is 1 for exactly NODES cycles. dout_o carries node 0 first and then each higher node in turn. busy_o then returns to 0.
- R9: A start_i pulse while busy_o is 1 is ignored, and the run in progress finishes with its original pixels and settings.
- R10: done_o is high for exactly one cycle, and that cycle is the one carrying the first readout word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Load the pixels and begin a run (used only when idle) |
| pix_i | input | NODES*PW | Pixel intensities, unsigned, node 0 in the low byte |
| steps_i | input | STEPW | Number of update steps |
| sign_pat_i | input | 2**STEPW-1 | Leak direction per step, bit k for step k (1 = amplify) |
| kc_i | input | KW | Coupling shift |
| kg_i | input | KW | Leak shift |
| busy_o | output | 1 | High from start until the last readout word |
| done_o | output | 1 | One-cycle pulse with the first readout word |
| dout_valid_o | output | 1 | Readout word valid |
| dout_o | output | VW | Readout node value, signed Q8.8 |

## Verification
The bench builds the block with its default parameters: 16 nodes, 16-bit Q8.8 values, 8-bit pixels and a 5-bit step count. This places the 31-step maximum run within reach. It also places load-time clipping within reach, because any pixel of 128 or more exceeds the positive range. An impulse at node 7 reaches both array edges within a short run, which exercises both boundaries alongside the symmetric interior. Amplify steps on a flat image of 127 drive every node into saturation.

// File: rtl/diffnet_pkg.sv
package diffnet_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_READ = 2'd2
    } phase_e;
endpackage

// File: rtl/diffnet_cell.sv
module diffnet_cell #(
    parameter int VW = 16,
    parameter int KW = 4
) (
    input  logic [VW-1:0] left_i,
    input  logic [VW-1:0] self_i,
    input  logic [VW-1:0] right_i,
    input  logic [KW-1:0] kc_i,
    input  logic [KW-1:0] kg_i,
    input  logic          amp_i,
    output logic [VW-1:0] next_o
);
    localparam int EW = VW + 3;
    localparam logic signed [EW-1:0] HI = {{(EW-VW+1){1'b0}}, {(VW-1){1'b1}}};
    localparam logic signed [EW-1:0] LO = {{(EW-VW+1){1'b1}}, {(VW-1){1'b0}}};

    logic signed [EW-1:0] l_e, v_e, r_e, lap, cpl, leak, sum;

    always_comb begin
        l_e  = {{(EW-VW){left_i[VW-1]}}, left_i};
        v_e  = {{(EW-VW){self_i[VW-1]}}, self_i};
        r_e  = {{(EW-VW){right_i[VW-1]}}, right_i};
        lap  = l_e + r_e - (v_e <<< 1);
        cpl  = lap >>> kc_i;
        leak = v_e >>> kg_i;
        sum  = amp_i ? (v_e + cpl + leak) : (v_e + cpl - leak);
        if (sum > HI)      next_o = HI[VW-1:0];
        else if (sum < LO) next_o = LO[VW-1:0];
        else               next_o = sum[VW-1:0];
    end
endmodule

// File: rtl/diffnet_ctrl.sv
module diffnet_ctrl
    import diffnet_pkg::*;
#(
    parameter int NODES = 16,
    parameter int STEPW = 5,
    parameter int KW    = 4
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  start_i,
    input  logic [STEPW-1:0]      steps_i,
    input  logic [2**STEPW-2:0]   pat_i,
    input  logic [KW-1:0]         kc_i,
    input  logic [KW-1:0]         kg_i,
    output logic                  load_o,
    output logic                  step_o,
    output logic                  shift_o,
    output logic                  amp_o,
    output logic [KW-1:0]         kc_o,
    output logic [KW-1:0]         kg_o,
    output logic                  busy_o,
    output logic                  done_o,
    output logic                  valid_o
);
    localparam int MAXS = 2**STEPW - 1;
    localparam int RW   = $clog2(NODES);

    typedef struct packed {
        phase_e            phase;
        logic [STEPW-1:0]  idx;
        logic [STEPW-1:0]  steps;
        logic [MAXS-1:0]   pat;
        logic [KW-1:0]     kc;
        logic [KW-1:0]     kg;
        logic [RW-1:0]     rcnt;
        logic              done;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        load_o    = 1'b0;
        step_o    = 1'b0;
        shift_o   = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    load_o     = 1'b1;
                    st_d.steps = steps_i;
                    st_d.pat   = pat_i;
                    st_d.kc    = kc_i;
                    st_d.kg    = kg_i;
                    st_d.idx   = '0;
                    st_d.rcnt  = '0;
                    if (steps_i == '0) begin
                        st_d.phase = PH_READ;
                        st_d.done  = 1'b1;
                    end else begin
                        st_d.phase = PH_RUN;
                    end
                end
            end
            PH_RUN: begin
                step_o   = 1'b1;
                st_d.idx = st_q.idx + STEPW'(1);
                if (st_q.idx == st_q.steps - STEPW'(1)) begin
                    st_d.phase = PH_READ;
                    st_d.done  = 1'b1;
                end
            end
            PH_READ: begin
                shift_o   = 1'b1;
                st_d.rcnt = st_q.rcnt + RW'(1);
                if (st_q.rcnt == RW'(NODES - 1)) st_d.phase = PH_IDLE;
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign amp_o   = st_q.pat[st_q.idx];
    assign kc_o    = st_q.kc;
    assign kg_o    = st_q.kg;
    assign busy_o  = (st_q.phase != PH_IDLE);
    assign done_o  = st_q.done;
    assign valid_o = (st_q.phase == PH_READ);

    // R3: the step index never reaches the programmed count while running
    a_r3_idx_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.phase == PH_RUN) |-> (st_q.idx < st_q.steps));

    // R9: captured settings hold while a run is in progress
    a_r9_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.phase != PH_IDLE) |=> ($stable(st_q.steps) && $stable(st_q.pat)
                                     && $stable(st_q.kc) && $stable(st_q.kg)));
endmodule

// File: rtl/diffnet_array.sv
module diffnet_array
    import diffnet_pkg::*;
#(
    parameter int NODES = 16,
    parameter int VW    = 16,
    parameter int FRAC  = 8,
    parameter int PW    = 8,
    parameter int STEPW = 5,
    parameter int KW    = 4
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  start_i,
    input  logic [NODES*PW-1:0]   pix_i,
    input  logic [STEPW-1:0]      steps_i,
    input  logic [2**STEPW-2:0]   sign_pat_i,
    input  logic [KW-1:0]         kc_i,
    input  logic [KW-1:0]         kg_i,
    output logic                  busy_o,
    output logic                  done_o,
    output logic                  dout_valid_o,
    output logic [VW-1:0]         dout_o
);
    localparam int LW = PW + FRAC + VW;
    localparam logic [LW-1:0] MAXW = {{(PW+FRAC+1){1'b0}}, {(VW-1){1'b1}}};

    logic load, step, shift, amp;
    logic [KW-1:0] kc, kg;
    logic [VW-1:0] node_d [NODES];
    logic [VW-1:0] node_q [NODES];
    logic [VW-1:0] cell_next [NODES];
    logic [VW-1:0] load_val [NODES];

    diffnet_ctrl #(.NODES(NODES), .STEPW(STEPW), .KW(KW)) ctrl_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (start_i),
        .steps_i (steps_i),
        .pat_i   (sign_pat_i),
        .kc_i    (kc_i),
        .kg_i    (kg_i),
        .load_o  (load),
        .step_o  (step),
        .shift_o (shift),
        .amp_o   (amp),
        .kc_o    (kc),
        .kg_o    (kg),
        .busy_o  (busy_o),
        .done_o  (done_o),
        .valid_o (dout_valid_o)
    );

    for (genvar i = 0; i < NODES; i++) begin : g_node
        logic [VW-1:0] lft, rgt;
        logic [LW-1:0] wide;
        if (i == 0) begin : g_lo
            assign lft = node_q[i];
        end else begin : g_li
            assign lft = node_q[i-1];
        end
        if (i == NODES - 1) begin : g_ro
            assign rgt = node_q[i];
        end else begin : g_ri
            assign rgt = node_q[i+1];
        end
        assign wide        = {{VW{1'b0}}, pix_i[i*PW +: PW], {FRAC{1'b0}}};
        assign load_val[i] = (wide > MAXW) ? MAXW[VW-1:0] : wide[VW-1:0];

        diffnet_cell #(.VW(VW), .KW(KW)) cell_i (
            .left_i  (lft),
            .self_i  (node_q[i]),
            .right_i (rgt),
            .kc_i    (kc),
            .kg_i    (kg),
            .amp_i   (amp),
            .next_o  (cell_next[i])
        );
    end

    always_comb begin
        for (int i = 0; i < NODES; i++) begin
            if (load)       node_d[i] = load_val[i];
            else if (step)  node_d[i] = cell_next[i];
            else if (shift) node_d[i] = (i == NODES - 1) ? '0 : node_q[(i + 1) % NODES];
            else            node_d[i] = node_q[i];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < NODES; i++) node_q[i] <= '0;
        end else begin
            for (int i = 0; i < NODES; i++) node_q[i] <= node_d[i];
        end
    end

    assign dout_o = node_q[0];

    // R8: readout words appear only inside a busy window
    a_r8_valid_needs_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dout_valid_o |-> busy_o);

    // R10: done lasts one cycle
    a_r10_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R10: done coincides with the first readout word only
    a_r10_done_first_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(dout_valid_o) |-> done_o);

    // R9: a start while busy never reloads the nodes
    a_r9_no_reload_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !dout_valid_o) |-> !load);
endmodule

// File: tb/diffnet_array_tb_top.sv
module diffnet_array_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NODES = 16;
    localparam int PW = 8;
    localparam int MAXS = 31;

    typedef struct packed {
        logic [4:0]  steps;
        logic [30:0] pat;
        logic [3:0]  kc;
        logic [3:0]  kg;
        logic [1:0]  kind;
        logic [3:0]  pos;
        logic [7:0]  amp;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{5'd0,  31'h0,        4'd2, 4'd4, 2'd0, 4'd3,  8'd50},
        '{5'd4,  31'h0,        4'd2, 4'd4, 2'd0, 4'd7,  8'd100},
        '{5'd6,  31'h2A,       4'd2, 4'd3, 2'd0, 4'd7,  8'd100},
        '{5'd5,  31'h1F,       4'd1, 4'd5, 2'd0, 4'd0,  8'd80},
        '{5'd3,  31'h0,        4'd2, 4'd6, 2'd2, 4'd0,  8'd10},
        '{5'd1,  31'h1,        4'd2, 4'd2, 2'd1, 4'd0,  8'd127},
        '{5'd2,  31'h0,        4'd3, 4'd8, 2'd1, 4'd0,  8'd200},
        '{5'd31, 31'h55555555, 4'd2, 4'd4, 2'd0, 4'd15, 8'd120}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [NODES*PW-1:0] pix = '0;
    logic [4:0] steps = '0;
    logic [30:0] pat = '0;
    logic [3:0] kc = '0, kg = '0;
    logic busy, done, dvalid;
    logic [15:0] dout;

    int total = 0;
    int bad = 0;
    int got [NODES];

    always #(CLK_PERIOD/2) clk = ~clk;

    diffnet_array dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pix_i(pix),
        .steps_i(steps), .sign_pat_i(pat), .kc_i(kc), .kg_i(kg),
        .busy_o(busy), .done_o(done), .dout_valid_o(dvalid), .dout_o(dout)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int clip(input int x);
        if (x > 32767) return 32767;
        if (x < -32768) return -32768;
        return x;
    endfunction

    function automatic logic [NODES*PW-1:0] make_pix(input vec_t v);
        logic [NODES*PW-1:0] p = '0;
        for (int i = 0; i < NODES; i++) begin
            case (v.kind)
                2'd0: p[i*PW +: PW] = (i == int'(v.pos)) ? v.amp : 8'd0;
                2'd1: p[i*PW +: PW] = v.amp;
                default: p[i*PW +: PW] = 8'((int'(v.amp) + 16 * i) % 256);
            endcase
        end
        return p;
    endfunction

    // independent model of the requirement equations (R2, R4, R5, R6, R7)
    task automatic model(input vec_t v, input logic [NODES*PW-1:0] p, output int m [NODES]);
        int nx [NODES];
        for (int i = 0; i < NODES; i++) m[i] = clip(int'(p[i*PW +: PW]) * 256);
        for (int k = 0; k < int'(v.steps); k++) begin
            for (int i = 0; i < NODES; i++) begin
                int l, r, c, g;
                l = (i == 0) ? m[i] : m[i-1];
                r = (i == NODES - 1) ? m[i] : m[i+1];
                c = (l + r - 2 * m[i]) >>> int'(v.kc);
                g = m[i] >>> int'(v.kg);
                nx[i] = clip(v.pat[k] ? (m[i] + c + g) : (m[i] + c - g));
            end
            for (int i = 0; i < NODES; i++) m[i] = nx[i];
        end
    endtask

    // runs one vector; glitch=1 pulses start with other settings mid-run (R9)
    task automatic run(input vec_t v, input bit glitch, input string tag);
        int exp [NODES];
        int cyc;
        logic [NODES*PW-1:0] p;
        p = make_pix(v);
        model(v, p, exp);
        @(negedge clk);
        pix = p; steps = v.steps; pat = v.pat; kc = v.kc; kg = v.kg; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 100) begin
            if (glitch && cyc == 1) begin
                pix = ~p; steps = 5'd2; kc = 4'd0; kg = 4'd1; pat = '1; start = 1'b1;
            end
            @(posedge clk);
            @(negedge clk);
            start = 1'b0;
            cyc++;
        end
        chk(cyc == int'(v.steps), {tag, " R3 done timing"}, cyc, int'(v.steps));
        for (int i = 0; i < NODES; i++) begin
            chk(dvalid == 1'b1, {tag, " R8 valid"}, int'(dvalid), 1);
            chk(done == (i == 0), {tag, " R10 done pulse"}, int'(done), int'(i == 0));
            got[i] = int'($signed(dout));
            chk(got[i] == exp[i], $sformatf("%s R4 node %0d", tag, i), got[i], exp[i]);
            @(posedge clk);
            @(negedge clk);
        end
        chk(dvalid == 1'b0 && busy == 1'b0, {tag, " R8 end of readout"},
            int'({busy, dvalid}), 0);
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int prev_peak;
        vec_t v;
        #(CLK_PERIOD * 3);
        @(negedge clk);
        chk(busy == 0 && done == 0 && dvalid == 0, "R1 reset outputs",
            int'({busy, done, dvalid}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && dvalid == 0, "R1 idle after reset", int'({busy, dvalid}), 0);

        for (int n = 0; n < NV; n++) run(VECS[n], 1'b0, $sformatf("vec%0d", n));

        // R2: zero steps reads the load back; node 3 = 50*256, others 0
        run(VECS[0], 1'b0, "R2 load");
        chk(got[3] == 12800, "R2 impulse load", got[3], 12800);
        // R2: pixel 200 clips at load; flat image stays flat under zero flux (R5)
        v = VECS[6]; v.steps = 5'd0;
        run(v, 1'b0, "R2 clip");
        chk(got[5] == 32767, "R2 clipped load", got[5], 32767);

        // R5: flat image with kg=15 keeps every node at its loaded value
        v = VECS[6]; v.amp = 8'd20; v.kg = 4'd15;
        run(v, 1'b0, "R5 flat");
        chk(got[0] == 5120 && got[15] == 5120, "R5 zero flux edges", got[15], 5120);

        // R6: impulse at node 7, 4 decay steps, mirror symmetric
        run(VECS[1], 1'b0, "R6 sym");
        for (int d = 1; d <= 4; d++)
            chk(got[7-d] == got[7+d], $sformatf("R6 symmetry d=%0d", d), got[7-d], got[7+d]);

        // R7: decay only, peak strictly falls with step count
        prev_peak = 32768;
        for (int s = 1; s <= 4; s++) begin
            v = VECS[1]; v.steps = 5'(s);
            run(v, 1'b0, $sformatf("R7 decay%0d", s));
            chk(got[7] < prev_peak, "R7 peak falls", got[7], prev_peak);
            prev_peak = got[7];
        end

        // R4: amplify on flat 127 saturates every node
        run(VECS[5], 1'b0, "R4 sat");
        chk(got[8] == 32767, "R4 saturation", got[8], 32767);

        // R9: a mid-run start must not disturb the result
        run(VECS[2], 1'b1, "R9 ignore start");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule